// File: doc/BRIEF.md
# Triangular Block-Pair Sequencer

This block drives a correlation tile that works on square groups of receivers. A correlation matrix is symmetric, so only its lower triangle needs computing. The sequencer walks through every pair of receiver groups that lies in that triangle, including the pairs on the diagonal. For each pair it presents the first receiver index of the X group and of the Y group. It holds that pair until the tile reports, with a one-cycle advance pulse, that it has finished with it.

Two coordinates are kept in receiver units. After each pair, Y moves up by one group width. When Y would pass X, X moves to the next group and Y returns to zero. Only the triangular set is generated, with no rectangular sweep and no skipped slots. A running pair index counts the issued pairs. A last flag marks the final pair. Once that pair is acknowledged, the sequencer goes idle until the next start pulse.

Top module: `tri_pair_seq`

## Requirements
- R1: While and after reset, valid_o, last_o, x_base_o, y_base_o and pair_idx_o are all 0.
- R2: A start_i pulse while idle makes valid_o high on the next cycle, with x_base_o = 0, y_base_o = 0 and pair_idx_o = 0.
- R3: An advance_i pulse while valid_o is high on a non-final pair sets the next cycle's Y to Y+BLK. If that sum exceeds X, the next X is X+BLK and the next Y is 0 instead.
- R4: Over one run, the issued pairs are exactly all (x, y) with y ≤ x, both multiples of BLK below NUM_RX. With N = NUM_RX/BLK there are N(N+1)/2 of them, in X-major, Y-minor order.
- R5: pair_idx_o starts at 0 for each run and rises by exactly 1 per accepted advance.
- R6: While valid_o is high and advance_i is low, x_base_o, y_base_o, pair_idx_o and last_o hold their values.
- R7: last_o is high exactly on the pair with index N(N+1)/2−1, which is x = y = NUM_RX−BLK.
- R8: An advance on the final pair drops valid_o on the next cycle. A later start begins a fresh run from pair 0.
- R9: start_i while valid_o is high, and advance_i while idle, have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a run when idle |
| advance_i | input | 1 | Tile has finished the current pair |
| valid_o | output | 1 | A pair is being presented |
| x_base_o | output | CW | First receiver index of the X group |
| y_base_o | output | CW | First receiver index of the Y group |
| last_o | output | 1 | Current pair is the final one of the run |
| pair_idx_o | output | IW | Running index of the current pair |

## Verification
The hardest point to reach is the final pair and the step after it. It comes only after thousands of acknowledged pairs, and it is the only place where the coordinate end test and the index counter must agree. The stimulus walks the complete triangle for two group widths (8 and 16). Each emitted pair is compared with a nested-loop model, and idle gaps of varying length are inserted before each advance. The walk is then repeated from a fresh start to show that a run restarts cleanly.

// File: rtl/tri_seq_pkg.sv
package tri_seq_pkg;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_ISSUE = 1'b1
    } seq_state_e;

    function automatic int unsigned group_count(input int unsigned rx, input int unsigned blk);
        return rx / blk;
    endfunction

    function automatic int unsigned tri_pairs(input int unsigned n);
        return (n * (n + 1)) / 2;
    endfunction

    function automatic int unsigned bits_for(input int unsigned v);
        return (v <= 1) ? 1 : $clog2(v);
    endfunction

endpackage

// File: rtl/tri_coord_step.sv
module tri_coord_step
    import tri_seq_pkg::*;
#(
    parameter int unsigned NUM_RX = 576,
    parameter int unsigned BLK    = 8,
    parameter int unsigned CW     = 10
) (
    input  logic [CW-1:0] x_i,
    input  logic [CW-1:0] y_i,
    output logic [CW-1:0] x_next_o,
    output logic [CW-1:0] y_next_o,
    output logic          at_end_o
);
    localparam int unsigned N_GRP = group_count(NUM_RX, BLK);
    localparam logic [CW-1:0] EDGE = CW'((N_GRP - 1) * BLK);
    localparam logic [CW:0]   STEP_W = (CW+1)'(BLK);

    logic [CW:0] y_sum;
    logic        wrap;

    always_comb begin
        y_sum = {1'b0, y_i} + STEP_W;
        wrap  = (y_sum > {1'b0, x_i});
        if (wrap) begin
            x_next_o = x_i + CW'(BLK);
            y_next_o = '0;
        end else begin
            x_next_o = x_i;
            y_next_o = y_sum[CW-1:0];
        end
        at_end_o = (x_i == EDGE) && (y_i == EDGE);
    end
endmodule

// File: rtl/tri_pair_counter.sv
module tri_pair_counter #(
    parameter int unsigned PAIRS = 2628,
    parameter int unsigned IW    = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_i,
    input  logic          inc_i,
    output logic [IW-1:0] count_o,
    output logic          final_o
);
    localparam logic [IW-1:0] FINAL_IDX = IW'(PAIRS - 1);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            count_o <= '0;
        end else if (inc_i) begin
            count_o <= count_o + 1'b1;
        end
    end

    assign final_o = (count_o == FINAL_IDX);

    // R5: each accepted increment moves the index by exactly one
    a_r5_count_step: assert property (@(posedge clk) disable iff (rst)
        (inc_i && !clr_i) |=> (count_o == $past(count_o) + 1'b1));

    // R5: clearing always returns the index to zero
    a_r5_count_clear: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (count_o == '0));
endmodule

// File: rtl/tri_pair_seq.sv
module tri_pair_seq
    import tri_seq_pkg::*;
#(
    parameter int unsigned NUM_RX = 576,
    parameter int unsigned BLK    = 8,
    parameter int unsigned CW     = bits_for(NUM_RX),
    parameter int unsigned IW     = bits_for(tri_pairs(group_count(NUM_RX, BLK)))
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          advance_i,
    output logic          valid_o,
    output logic [CW-1:0] x_base_o,
    output logic [CW-1:0] y_base_o,
    output logic          last_o,
    output logic [IW-1:0] pair_idx_o
);
    localparam int unsigned N_GRP = group_count(NUM_RX, BLK);
    localparam int unsigned PAIRS = tri_pairs(N_GRP);

    seq_state_e    state_q;
    logic [CW-1:0] x_q, y_q;
    logic [CW-1:0] x_nx, y_nx;
    logic          coord_end;
    logic          cnt_final;
    logic          go, step, finish;

    tri_coord_step #(
        .NUM_RX (NUM_RX),
        .BLK    (BLK),
        .CW     (CW)
    ) u_step (
        .x_i      (x_q),
        .y_i      (y_q),
        .x_next_o (x_nx),
        .y_next_o (y_nx),
        .at_end_o (coord_end)
    );

    always_comb begin
        go     = (state_q == SEQ_IDLE) && start_i;
        step   = (state_q == SEQ_ISSUE) && advance_i && !cnt_final;
        finish = (state_q == SEQ_ISSUE) && advance_i && cnt_final;
    end

    tri_pair_counter #(
        .PAIRS (PAIRS),
        .IW    (IW)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (go || finish),
        .inc_i   (step),
        .count_o (pair_idx_o),
        .final_o (cnt_final)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            x_q     <= '0;
            y_q     <= '0;
        end else if (go) begin
            state_q <= SEQ_ISSUE;
            x_q     <= '0;
            y_q     <= '0;
        end else if (finish) begin
            state_q <= SEQ_IDLE;
            x_q     <= '0;
            y_q     <= '0;
        end else if (step) begin
            x_q <= x_nx;
            y_q <= y_nx;
        end
    end

    assign valid_o  = (state_q == SEQ_ISSUE);
    assign x_base_o = x_q;
    assign y_base_o = y_q;
    assign last_o   = valid_o && cnt_final;

    // R4: presented pairs never leave the lower triangle
    a_r4_lower_tri: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (y_base_o <= x_base_o));

    // R7: index counter and coordinate end test agree on the final pair
    a_r7_last_agree: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (last_o == coord_end));

    // R6: pair held while no advance arrives
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !advance_i) |=> (valid_o && $stable(x_base_o) && $stable(y_base_o)
                                     && $stable(pair_idx_o)));

    // R2: a start from idle presents the origin pair
    a_r2_start: assert property (@(posedge clk) disable iff (rst)
        (!valid_o && start_i) |=> (valid_o && x_base_o == '0 && y_base_o == '0
                                   && pair_idx_o == '0));

    // R8: acknowledging the final pair ends the run
    a_r8_end_run: assert property (@(posedge clk) disable iff (rst)
        (last_o && advance_i) |=> !valid_o);

    // R9: advance while idle leaves the sequencer idle
    a_r9_idle_adv: assert property (@(posedge clk) disable iff (rst)
        (!valid_o && !start_i) |=> !valid_o);
endmodule

// File: tb/tri_pair_seq_tb.sv
`timescale 1ns/1ps
module tri_pair_seq_tb;
    localparam int unsigned RX = 576;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst;
    logic [1:0] st, adv;

    logic        v8, l8;
    logic [9:0]  x8, y8;
    logic [11:0] i8;
    logic        v16, l16;
    logic [9:0]  x16, y16;
    logic [9:0]  i16;

    tri_pair_seq #(.NUM_RX(RX), .BLK(8)) u_dut (
        .clk(clk), .rst(rst), .start_i(st[0]), .advance_i(adv[0]),
        .valid_o(v8), .x_base_o(x8), .y_base_o(y8), .last_o(l8), .pair_idx_o(i8)
    );

    tri_pair_seq #(.NUM_RX(RX), .BLK(16)) u_dut_b16 (
        .clk(clk), .rst(rst), .start_i(st[1]), .advance_i(adv[1]),
        .valid_o(v16), .x_base_o(x16), .y_base_o(y16), .last_o(l16), .pair_idx_o(i16)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            total++;
            bad++;
            $display("FAIL R4 watchdog expired: actual=%0d cycles expected<=150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic peek(input int sel, output int v, output int x, output int y,
                        output int i, output int l);
        if (sel == 0) begin
            v = int'(v8); x = int'(x8); y = int'(y8); i = int'(i8); l = int'(l8);
        end else begin
            v = int'(v16); x = int'(x16); y = int'(y16); i = int'(i16); l = int'(l16);
        end
    endtask

    task automatic check_pair(input int sel, input int ex, input int ey, input int ek,
                              input int el, input string tag);
        int v, x, y, i, l;
        peek(sel, v, x, y, i, l);
        chk(v == 1,  {tag, " valid"}, v, 1);
        chk(x == ex, {tag, " x"}, x, ex);
        chk(y == ey, {tag, " y"}, y, ey);
        chk(i == ek, {tag, " idx"}, i, ek);
        chk(l == el, {tag, " last"}, l, el);
    endtask

    task automatic walk(input int sel, input int b);
        int n, pairs, k, g, v, x, y, i, l;
        n = RX / b;
        pairs = n * (n + 1) / 2;
        k = 0;
        @(negedge clk) st[sel] = 1'b1;
        @(negedge clk) st[sel] = 1'b0;
        check_pair(sel, 0, 0, 0, 0, "R2 start");
        for (int xb = 0; xb < n; xb++) begin
            for (int yb = 0; yb <= xb; yb++) begin
                // R3 R4 R5 R7: nested-loop model of the triangle
                check_pair(sel, xb * b, yb * b, k, (k == pairs - 1) ? 1 : 0, "R3/R4/R5/R7 pair");
                g = (k * 7) % 3;
                repeat (g) @(negedge clk);
                if (g > 0)
                    check_pair(sel, xb * b, yb * b, k, (k == pairs - 1) ? 1 : 0, "R6 hold");
                if (k == 5) begin
                    st[sel] = 1'b1;
                    @(negedge clk) st[sel] = 1'b0;
                    check_pair(sel, xb * b, yb * b, k, 0, "R9 start while busy");
                end
                adv[sel] = 1'b1;
                @(negedge clk) adv[sel] = 1'b0;
                k++;
            end
        end
        peek(sel, v, x, y, i, l);
        chk(v == 0, "R8 idle after final", v, 0);
        chk(l == 0, "R8 last cleared", l, 0);
        chk(k == pairs, "R4 pair total", k, pairs);
    endtask

    initial begin
        int v, x, y, i, l;
        rst = 1'b1;
        st  = '0;
        adv = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        for (int s = 0; s < 2; s++) begin
            peek(s, v, x, y, i, l);
            chk(v == 0, "R1 valid", v, 0);
            chk(x == 0, "R1 x", x, 0);
            chk(y == 0, "R1 y", y, 0);
            chk(i == 0, "R1 idx", i, 0);
            chk(l == 0, "R1 last", l, 0);
        end
        adv = 2'b11;
        @(negedge clk) adv = '0;
        for (int s = 0; s < 2; s++) begin
            peek(s, v, x, y, i, l);
            chk(v == 0, "R9 advance while idle", v, 0);
            chk(i == 0, "R9 idx untouched", i, 0);
        end
        walk(0, 8);
        walk(1, 16);
        walk(1, 16); // R8: a second run restarts from pair 0
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule